// File: doc/BRIEF.md
# I2C GPIO Expander Target

This block lets an I2C controller run an 8-bit general-purpose port. It watches oversampled SCL and SDA levels, recognises START, repeated START and STOP, answers one 7-bit address and pulls SDA low through an open-drain enable. The first byte after the address picks a register. Later bytes in a write go into that register. A controller that reads sends a repeated START, and the block then sends bytes from the same register until the controller answers with NACK. The pointer never advances by itself, so each extra byte of a continued read is the same register again.

On the port side the block drives an output value and a direction mask, and takes in the live pin levels. The pin levels are XORed with a polarity mask before they go out on the bus. An input bit that is not masked and that changes value raises an interrupt flag and pulls the active-low interrupt pin down. Only a read of the input port clears it. Every byte of an input-port read carries a fresh sample of the pins, so the controller can poll the pins by simply continuing the read.

Top module: `gpio_i2c_target`

## Requirements
- R1: After reset: `port_out` = 0xFF, `port_dir` = 0xFF (a 1 means input), polarity = 0x00, interrupt mask = 0xFF (a 1 means masked), `int_n` = 1 and `sda_oe` = 0.
- R2: The target acknowledges an address byte whose upper seven bits equal {6'b100000, `addr_sel`}, bit 0 being R/W (1 = read). Any other address gets NACK, and every byte up to the next START or STOP is ignored.
- R3: The first byte after an address with W is the command byte. Command 0x0A selects the output register. A data byte written to it reaches `port_out` only on the SCL falling edge that ends the target's ACK of that data byte.
- R4: Writable registers and their command codes: 0x01 polarity, 0x02 hold enable, 0x03 pull select, 0x04 direction (drives `port_dir`), 0x05 interrupt mask, 0x0A output. After a repeated START with R, each of them reads back the last value written.
- R5: A command code outside {0x00..0x06, 0x0A} reads as 0x00, and data written to it changes nothing.
- R6: Command 0x00 reads the input port as `port_in` XOR polarity, sampled on the SCL falling edge just before the first data bit of the byte.
- R7: The command pointer does not advance. Each further byte of a continued read comes from the same register, and for the input port each byte is a new sample.
- R8: A change on an input bit whose mask bit is 0 sets that bit in the interrupt status register (command 0x06, read only) and drives `int_n` low. Changes on masked bits do not.
- R9: The interrupt status is cleared at the controller's ACK/NACK clock of an input-port (0x00) byte. Reading any other register leaves it as it is.
- R10: A STOP at any point releases SDA, returns the target to idle and commits no partial byte. The next transaction works normally.
- R11: SDA is driven only during ACK slots of accepted bytes and the data bits of read bytes. Its enable changes only on an SCL falling edge, a START or a STOP, and it is never set while the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 1 | Least significant address bit |
| port_in | input | 8 | Live pin levels |
| port_out | output | 8 | Output register value |
| port_dir | output | 8 | Direction mask, 1 = input |
| int_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a continued input-port read in which the pins change between two bytes. The change must land after the previous byte has been shifted out but before the SCL falling edge that loads the next one. The bench gets there by changing `port_in` just before it drives each controller ACK bit, so every byte of a three-byte poll must show the value set during the ACK just before it. Two further cases must be steered from the pins: a masked pin change that must not raise the interrupt, and a status read that must not clear it.

// File: rtl/gpio_i2c_pkg.sv
package gpio_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [5:0] DEV_ID_HI = 6'b100000;

    localparam logic [BYTE_W-1:0] CMD_INPUT  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_POL    = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_HOLD   = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_PULL   = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_DIR    = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_MASK   = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_STATUS = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_OUTPUT = 8'h0A;

    typedef enum logic [3:0] {
        LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_CMD, LS_CMD_ACK,
        LS_WDATA, LS_WDATA_ACK, LS_RDATA, LS_RDATA_ACK
    } link_st_e;
endpackage

// File: rtl/gpio_i2c_sync.sv
module gpio_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic bus_start,
    output logic bus_stop
);
    localparam int PREV = STAGES;
    localparam int CUR  = STAGES - 1;

    typedef struct packed {
        logic [PREV:0] scl;
        logic [PREV:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[PREV-1:0], scl_i};
        s_d.sda = {s_q.sda[PREV-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign sda_lvl   = s_q.sda[CUR];
    assign scl_rise  = s_q.scl[CUR] & ~s_q.scl[PREV];
    assign scl_fall  = ~s_q.scl[CUR] & s_q.scl[PREV];
    assign bus_start = s_q.scl[CUR] & s_q.scl[PREV] & ~s_q.sda[CUR] & s_q.sda[PREV];
    assign bus_stop  = s_q.scl[CUR] & s_q.scl[PREV] & s_q.sda[CUR] & ~s_q.sda[PREV];
endmodule

// File: rtl/gpio_i2c_link.sv
module gpio_i2c_link
    import gpio_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_we,
    output logic              wr_we,
    output logic              rd_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              link_idle
);
    typedef struct packed {
        link_st_e          st;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              oe;
        logic              mack;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d     = l_q;
        cmd_we  = 1'b0;
        wr_we   = 1'b0;
        rd_done = 1'b0;
        if (bus_stop) begin
            l_d.st = LS_IDLE;
            l_d.oe = 1'b0;
        end else if (bus_start) begin
            l_d.st   = LS_ADDR;
            l_d.bits = '0;
            l_d.oe   = 1'b0;
        end else begin
            unique case (l_q.st)
                LS_ADDR, LS_CMD, LS_WDATA: begin
                    if (scl_rise && l_q.bits != CNT_W'(BYTE_W)) begin
                        l_d.sh   = {l_q.sh[BYTE_W-2:0], sda_lvl};
                        l_d.bits = l_q.bits + 1'b1;
                    end
                    if (scl_fall && l_q.bits == CNT_W'(BYTE_W)) begin
                        l_d.bits = '0;
                        if (l_q.st == LS_ADDR) begin
                            if (l_q.sh[BYTE_W-1:1] == {DEV_ID_HI, addr_sel}) begin
                                l_d.rw = l_q.sh[0];
                                l_d.oe = 1'b1;
                                l_d.st = LS_ADDR_ACK;
                            end else begin
                                l_d.st = LS_IDLE;
                            end
                        end else if (l_q.st == LS_CMD) begin
                            cmd_we = 1'b1;
                            l_d.oe = 1'b1;
                            l_d.st = LS_CMD_ACK;
                        end else begin
                            l_d.oe = 1'b1;
                            l_d.st = LS_WDATA_ACK;
                        end
                    end
                end
                LS_ADDR_ACK: if (scl_fall) begin
                    if (l_q.rw) begin
                        l_d.st   = LS_RDATA;
                        l_d.sh   = rd_data;
                        l_d.oe   = ~rd_data[BYTE_W-1];
                        l_d.bits = '0;
                    end else begin
                        l_d.oe = 1'b0;
                        l_d.st = LS_CMD;
                    end
                end
                LS_CMD_ACK: if (scl_fall) begin
                    l_d.oe = 1'b0;
                    l_d.st = LS_WDATA;
                end
                LS_WDATA_ACK: if (scl_fall) begin
                    l_d.oe = 1'b0;
                    wr_we  = 1'b1;
                    l_d.st = LS_WDATA;
                end
                LS_RDATA: if (scl_fall) begin
                    if (l_q.bits == CNT_W'(BYTE_W - 1)) begin
                        l_d.oe = 1'b0;
                        l_d.st = LS_RDATA_ACK;
                    end else begin
                        l_d.sh   = {l_q.sh[BYTE_W-2:0], 1'b0};
                        l_d.oe   = ~l_q.sh[BYTE_W-2];
                        l_d.bits = l_q.bits + 1'b1;
                    end
                end
                LS_RDATA_ACK: begin
                    if (scl_rise) begin
                        l_d.mack = ~sda_lvl;
                        rd_done  = 1'b1;
                    end
                    if (scl_fall) begin
                        if (l_q.mack) begin
                            l_d.st   = LS_RDATA;
                            l_d.sh   = rd_data;
                            l_d.oe   = ~rd_data[BYTE_W-1];
                            l_d.bits = '0;
                        end else begin
                            l_d.st = LS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{st: LS_IDLE, default: '0};
        else        l_q <= l_d;
    end

    assign sda_oe    = l_q.oe;
    assign rx_byte   = l_q.sh;
    assign link_idle = (l_q.st == LS_IDLE);
endmodule

// File: rtl/gpio_i2c_regs.sv
module gpio_i2c_regs
    import gpio_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              wr_we,
    input  logic              rd_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] port_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] port_out,
    output logic [BYTE_W-1:0] port_dir,
    output logic              int_n,
    output logic              int_clr
);
    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] pol;
        logic [BYTE_W-1:0] hold;
        logic [BYTE_W-1:0] pull;
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] outp;
        logic [BYTE_W-1:0] prev;
        logic              vld;
    } regs_t;

    regs_t r_d, r_q;
    logic [BYTE_W-1:0] chg;

    always_comb begin
        r_d      = r_q;
        r_d.prev = port_in;
        r_d.vld  = 1'b1;
        chg      = r_q.vld ? ((port_in ^ r_q.prev) & ~r_q.mask) : '0;
        int_clr  = rd_done && (r_q.cmd == CMD_INPUT);
        r_d.status = (int_clr ? '0 : r_q.status) | chg;
        if (cmd_we) r_d.cmd = rx_byte;
        if (wr_we) begin
            unique case (r_q.cmd)
                CMD_POL:    r_d.pol  = rx_byte;
                CMD_HOLD:   r_d.hold = rx_byte;
                CMD_PULL:   r_d.pull = rx_byte;
                CMD_DIR:    r_d.dir  = rx_byte;
                CMD_MASK:   r_d.mask = rx_byte;
                CMD_OUTPUT: r_d.outp = rx_byte;
                default: ;
            endcase
        end
        unique case (r_q.cmd)
            CMD_INPUT:  rd_data = port_in ^ r_q.pol;
            CMD_POL:    rd_data = r_q.pol;
            CMD_HOLD:   rd_data = r_q.hold;
            CMD_PULL:   rd_data = r_q.pull;
            CMD_DIR:    rd_data = r_q.dir;
            CMD_MASK:   rd_data = r_q.mask;
            CMD_STATUS: rd_data = r_q.status;
            CMD_OUTPUT: rd_data = r_q.outp;
            default:    rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{dir: '1, mask: '1, outp: '1, default: '0};
        else        r_q <= r_d;
    end

    assign port_out = r_q.outp;
    assign port_dir = r_q.dir;
    assign int_n    = ~|r_q.status;
endmodule

// File: rtl/gpio_i2c_target.sv
module gpio_i2c_target
    import gpio_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] port_in,
    output logic [BYTE_W-1:0] port_out,
    output logic [BYTE_W-1:0] port_dir,
    output logic              int_n
);
    logic scl_rise, scl_fall, sda_lvl, bus_start, bus_stop;
    logic cmd_we, wr_we, rd_done, int_clr, link_idle;
    logic [BYTE_W-1:0] rx_byte, rd_data;

    gpio_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    gpio_i2c_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_sel(addr_sel), .rd_data(rd_data), .sda_oe(sda_oe),
        .cmd_we(cmd_we), .wr_we(wr_we), .rd_done(rd_done),
        .rx_byte(rx_byte), .link_idle(link_idle)
    );

    gpio_i2c_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .wr_we(wr_we),
        .rd_done(rd_done), .rx_byte(rx_byte), .port_in(port_in),
        .rd_data(rd_data), .port_out(port_out), .port_dir(port_dir),
        .int_n(int_n), .int_clr(int_clr)
    );
endmodule

// File: rtl/gpio_i2c_checker.sv
module gpio_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       sda_oe,
    input logic       link_idle,
    input logic [7:0] port_out,
    input logic       int_n,
    input logic       int_clr
);
    AST_OUT_ON_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out) |-> $past(scl_fall)); // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe); // R10

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        link_idle |-> !sda_oe); // R11

    AST_OE_ON_BUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop)); // R11

    AST_INT_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> $past(int_clr)); // R9
endmodule

bind gpio_i2c_target gpio_i2c_checker i_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .sda_oe(sda_oe), .link_idle(link_idle),
    .port_out(port_out), .int_n(int_n), .int_clr(int_clr)
);

// File: tb/test_gpio_i2c_target.sv
`timescale 1ns/1ps
module test_gpio_i2c_target;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h82;
    localparam logic [7:0] AR = 8'h83;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b1;
    logic [7:0] port_in = 8'h3C;
    logic sda_oe, int_n;
    logic [7:0] port_out, port_dir;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t exp_q[$];
    logic [7:0] obs_byte;
    event byte_ev;

    always #10 clk = ~clk;

    gpio_i2c_target i_gpio_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .port_in(port_in),
        .port_out(port_out), .port_dir(port_dir), .int_n(int_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q); scl = 1'b0; waitq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; waitq(Q); scl = 1'b1; waitq(Q); sda_m = 1'b1; waitq(Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; waitq(Q); scl = 1'b1; waitq(Q); scl = 1'b0; waitq(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); b = sda_line;
        scl = 1'b0; waitq(Q);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv_to_monitor();
        logic b;
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
        obs_byte = d;
        -> byte_ev;
        waitq(1);
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] v);
        logic a;
        i2c_start();
        send(AW, a);  chk("R2 addr ack", {7'd0, a}, 8'd1);
        send(cmd, a); chk("R2 cmd ack", {7'd0, a}, 8'd1);
        send(v, a);   chk("R2 data ack", {7'd0, a}, 8'd1);
        i2c_stop();
        waitq(4);
        chk("R11 released when idle", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic read_reg(input logic [7:0] cmd, input int n,
                            input logic [7:0] expv, input string req);
        logic a;
        exp_t e;
        i2c_start();
        send(AW, a);
        send(cmd, a);
        i2c_start();
        send(AR, a);  chk("R2 read addr ack", {7'd0, a}, 8'd1);
        for (int i = 0; i < n; i++) begin
            e.val = expv; e.req = req;
            exp_q.push_back(e);
            recv_to_monitor();
            wbit(i == n - 1);
        end
        i2c_stop();
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(byte_ev);
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R4 unexpected byte: actual %02h expected none", obs_byte);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, obs_byte, e.val);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic a;
        exp_t e;
        waitq(5);
        rst_n = 1'b1;
        waitq(5);
        chk("R1 port_out", port_out, 8'hFF);
        chk("R1 port_dir", port_dir, 8'hFF);
        chk("R1 int_n", {7'd0, int_n}, 8'd1);
        chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);

        write_reg(8'h04, 8'h0F);
        chk("R4 dir drives port_dir", port_dir, 8'h0F);
        read_reg(8'h04, 1, 8'h0F, "R4 dir readback");
        read_reg(8'h04, 2, 8'h0F, "R7 no auto-increment");
        write_reg(8'h01, 8'hF0);
        read_reg(8'h01, 1, 8'hF0, "R4 polarity readback");
        write_reg(8'h03, 8'hA5);
        read_reg(8'h03, 1, 8'hA5, "R4 pull readback");

        // R3: output changes only at the end of the data ACK
        i2c_start();
        send(AW, a); send(8'h0A, a);
        for (int i = 7; i >= 0; i--) wbit(8'h5A >> i);
        sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q);
        chk("R3 target acks data", {7'd0, sda_line}, 8'd0);
        chk("R3 output held during ACK", port_out, 8'hFF);
        scl = 1'b0; waitq(Q);
        chk("R3 output after ACK", port_out, 8'h5A);
        i2c_stop();
        read_reg(8'h0A, 1, 8'h5A, "R4 output readback");

        port_in = 8'h3C;
        read_reg(8'h00, 1, 8'hCC, "R6 input xor polarity");

        // R7: continued input read, pins change during each controller ACK
        i2c_start();
        send(AW, a); send(8'h00, a);
        i2c_start();
        port_in = 8'h11;
        send(AR, a);
        e.val = 8'hE1; e.req = "R7 poll byte 1"; exp_q.push_back(e);
        recv_to_monitor(); port_in = 8'h22; wbit(1'b0);
        e.val = 8'hD2; e.req = "R7 poll byte 2"; exp_q.push_back(e);
        recv_to_monitor(); port_in = 8'h44; wbit(1'b0);
        e.val = 8'hB4; e.req = "R7 poll byte 3"; exp_q.push_back(e);
        recv_to_monitor(); wbit(1'b1);
        i2c_stop();

        write_reg(8'h07, 8'h55);
        read_reg(8'h07, 1, 8'h00, "R5 unmapped reads zero");
        read_reg(8'h04, 1, 8'h0F, "R5 dir untouched");
        chk("R5 output untouched", port_out, 8'h5A);

        // R2: wrong address is ignored
        i2c_start();
        send(8'h80, a); chk("R2 mismatch nack", {7'd0, a}, 8'd0);
        send(8'h0A, a); send(8'h00, a);
        i2c_stop();
        waitq(4);
        chk("R2 ignored write", port_out, 8'h5A);

        // R8/R9: interrupt
        write_reg(8'h05, 8'hFE);
        port_in = 8'h4C; waitq(6);
        chk("R8 masked change", {7'd0, int_n}, 8'd1);
        port_in = 8'h4D; waitq(6);
        chk("R8 unmasked change", {7'd0, int_n}, 8'd0);
        read_reg(8'h06, 1, 8'h01, "R8 status bit");
        chk("R9 status read keeps int", {7'd0, int_n}, 8'd0);
        read_reg(8'h00, 1, 8'hBD, "R9 input read");
        waitq(4);
        chk("R9 cleared by input read", {7'd0, int_n}, 8'd1);

        // R10: STOP in the middle of a data byte
        i2c_start();
        send(AW, a); send(8'h0A, a);
        wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
        i2c_stop();
        waitq(4);
        chk("R10 sda released", {7'd0, sda_oe}, 8'd0);
        chk("R10 no partial write", port_out, 8'h5A);
        write_reg(8'h0A, 8'h33);
        chk("R10 next write works", port_out, 8'h33);

        waitq(20);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7 missing bytes: actual %0d expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule